// File: doc/BRIEF.md
# Strobe-Driven FIFO Controller with Rewind

This block is a single-device first-in first-out buffer that uses no addresses. A producer writes a word by pulsing an active-low write strobe. A consumer takes the oldest word by pulsing an active-low read strobe. Two internal pointers track where the next word is stored and where the next word is fetched from. An occupancy counter drives three active-low status outputs: empty, full and half-full.

All strobes are sampled in one system clock domain. An access happens in the clock cycle where the strobe is first seen low after having been seen high. A rewind input moves the read pointer back to the first location so that the data written since reset can be sent again. The write pointer is left where it is.

A sticky protocol-error output records any strobe falling edge that arrives while rewind is active. Such an edge is dropped.

Top module: `strobe_fifo`

## Requirements
- R1: While rst_ni is low, both pointers go to location 0. Afterwards empty_no=0, full_no=1, half_no=1, proto_err_o=0 and rdata_o=0. A strobe that is held low across the release of reset causes no access until it has been seen high.
- R2: A write strobe falling edge (wr_n_i seen high on one clock edge and low on the next) stores wdata_i at that clock edge, provided full_no is high. Words are stored in sequence.
- R3: A read strobe falling edge while empty_no is high loads rdata_o at that clock edge with the oldest stored word. Words come out in the order they were written, and this holds across pointer wrap-around.
- R4: full_no is low exactly when the occupancy equals DEPTH. Starting from reset with no reads, this happens after DEPTH writes.
- R5: empty_no is low exactly when the occupancy is zero. The read that empties the buffer still returns its word.
- R6: A write edge while full changes neither the stored data nor the flags.
- R7: A read edge while empty leaves rdata_o and the flags unchanged.
- R8: half_no goes low at a write edge whose occupancy before the write is at least DEPTH/2. It goes high only at a read strobe rising edge that finds the occupancy at or below DEPTH/2, or through R9.
- R9: In each cycle that rt_n_i is low, the read pointer goes to location 0. The occupancy becomes the number of words written since reset, saturated at DEPTH. The write pointer is unchanged. half_no is set low exactly when that occupancy exceeds DEPTH/2.
- R10: Strobe falling edges seen while rt_n_i is low perform no access. They set proto_err_o, which stays high until reset.
- R11: A write edge and a read edge in the same cycle are judged on the flags from before that cycle. Both are done when the buffer is neither empty nor full, leaving the occupancy unchanged. When full, only the read is done. When empty, only the write is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_n_i | input | 1 | Active-low write strobe |
| rd_n_i | input | 1 | Active-low read strobe |
| rt_n_i | input | 1 | Active-low rewind of the read pointer |
| wdata_i | input | WIDTH | Word to store |
| rdata_o | output | WIDTH | Last word read |
| empty_no | output | 1 | Low when no word is stored |
| full_no | output | 1 | Low when DEPTH words are stored |
| half_no | output | 1 | Low when more than half full (see R8) |
| proto_err_o | output | 1 | Sticky: strobe edge during rewind |

## Verification
The bench uses an 8-word configuration.

It first fills the buffer to full and drains it to empty, pushes extra strobes at both limits, and checks that nothing moves. A design that lets a write through when full would overwrite the oldest word. One that lets a read through when empty would corrupt rdata_o or wrap the occupancy.

It then sweeps every pairing of words written and words read before a rewind, and reads everything back. A design that rebuilds the occupancy from the pointers, or that fails to rewind, returns the wrong count or the wrong words, with the exactly-full case the most likely to go wrong.

It also covers simultaneous strobes at empty, mid and full occupancy, the hysteresis of the half flag around the mid point, and strobe pulses placed inside a rewind. A design with wrong priorities there would store data or fail to raise the error output.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  typedef struct packed {
    logic fall;
    logic rise;
  } strobe_ev_t;

  localparam int unsigned NUM_STROBES = 2;
  localparam int unsigned STB_WR = 0;
  localparam int unsigned STB_RD = 1;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge
  import strobe_fifo_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strobe_ni,
  output strobe_ev_t ev_o
);
  // Resets to "seen low" so a strobe held low across reset release is not an edge.
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= strobe_ni;
  end

  assign ev_o.fall = prev_q & ~strobe_ni;
  assign ev_o.rise = ~prev_q & strobe_ni;
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/fifo_ptr_ctrl.sv
module fifo_ptr_ctrl #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_fall_i,
  input  logic          rd_fall_i,
  input  logic          rd_rise_i,
  input  logic          rt_act_i,
  output logic          we_o,
  output logic          re_o,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o,
  output logic          empty_no,
  output logic          full_no,
  output logic          half_no,
  output logic          proto_err_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [CW-1:0] count_q, total_q;
  logic [AW-1:0] wptr_q, rptr_q;
  logic          half_nq, err_q;
  logic          wr_ok, rd_ok;

  assign wr_ok = wr_fall_i & ~rt_act_i & (count_q != FULL_CNT);
  assign rd_ok = rd_fall_i & ~rt_act_i & (count_q != '0);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      total_q <= '0;
      half_nq <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      if ((wr_fall_i | rd_fall_i) & rt_act_i) err_q <= 1'b1;
      if (rt_act_i) begin
        rptr_q  <= '0;
        count_q <= total_q;
        half_nq <= ~(total_q > HALF_CNT);
      end else begin
        if (wr_ok) wptr_q <= bump(wptr_q);
        if (rd_ok) rptr_q <= bump(rptr_q);
        if (wr_ok && !rd_ok)      count_q <= count_q + 1'b1;
        else if (rd_ok && !wr_ok) count_q <= count_q - 1'b1;
        if (wr_ok && total_q != FULL_CNT) total_q <= total_q + 1'b1;
        // Set wins over clear when both happen in one cycle.
        if (wr_ok && count_q >= HALF_CNT)         half_nq <= 1'b0;
        else if (rd_rise_i && count_q <= HALF_CNT) half_nq <= 1'b1;
      end
    end
  end

  assign we_o        = wr_ok;
  assign re_o        = rd_ok;
  assign wptr_o      = wptr_q;
  assign rptr_o      = rptr_q;
  assign empty_no    = (count_q != '0);
  assign full_no     = (count_q != FULL_CNT);
  assign half_no     = half_nq;
  assign proto_err_o = err_q;

  a_r4_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= FULL_CNT);
  a_r6_full_holds_wptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fall_i && !full_no && !rt_act_i) |=> $stable(wptr_q));
  a_r7_empty_holds_rptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fall_i && !empty_no && !rt_act_i) |=> $stable(rptr_q));
  a_r8_half_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!half_nq && !rd_rise_i && !rt_act_i) |=> !half_nq);
  a_r9_rewind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_act_i |=> (rptr_q == '0) && $stable(wptr_q));
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  a_r11_both_keep_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && rd_ok) |=> $stable(count_q));
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_n_i,
  input  logic             rd_n_i,
  input  logic             rt_n_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_no,
  output logic             full_no,
  output logic             half_no,
  output logic             proto_err_o
);
  logic [NUM_STROBES-1:0] strobe_n;
  strobe_ev_t             ev [NUM_STROBES];
  logic                   we, re;
  logic [AW-1:0]          wptr, rptr;

  assign strobe_n[STB_WR] = wr_n_i;
  assign strobe_n[STB_RD] = rd_n_i;

  for (genvar g = 0; g < NUM_STROBES; g++) begin : g_edge
    strobe_edge u_edge (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .strobe_ni (strobe_n[g]),
      .ev_o      (ev[g])
    );
  end

  fifo_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_fall_i   (ev[STB_WR].fall),
    .rd_fall_i   (ev[STB_RD].fall),
    .rd_rise_i   (ev[STB_RD].rise),
    .rt_act_i    (~rt_n_i),
    .we_o        (we),
    .re_o        (re),
    .wptr_o      (wptr),
    .rptr_o      (rptr),
    .empty_no    (empty_no),
    .full_no     (full_no),
    .half_no     (half_no),
    .proto_err_o (proto_err_o)
  );

  fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (wptr),
    .wdata_i (wdata_i),
    .re_i    (re),
    .raddr_i (rptr),
    .rdata_o (rdata_o)
  );

  a_r5_read_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re |-> empty_no);
  a_r2_write_needs_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> full_no);
endmodule

// File: tb/strobe_fifo_tb_top.sv
`timescale 1ns/1ps
module strobe_fifo_tb_top;
  localparam int W = 9;
  localparam int D = 8;
  localparam int H = D / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_n = 1'b0, rd_n = 1'b1, rt_n = 1'b1;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic empty_n, full_n, half_n, perr;

  always #2.5 clk = ~clk;

  strobe_fifo #(.WIDTH(W), .DEPTH(D)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_n_i(wr_n), .rd_n_i(rd_n), .rt_n_i(rt_n),
    .wdata_i(wdata), .rdata_o(rdata), .empty_no(empty_n), .full_no(full_n),
    .half_no(half_n), .proto_err_o(perr)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Reference model
  logic [W-1:0] mm [D];
  int mc, mw, mr, mtot;
  logic mhalf, merr;
  logic [W-1:0] mlast;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string ctx);
    chk(empty_n == (mc != 0), {ctx, " R5 empty"}, int'(empty_n), int'(mc != 0));
    chk(full_n == (mc != D), {ctx, " R4 full"}, int'(full_n), int'(mc != D));
    chk(half_n == mhalf, {ctx, " R8 half"}, int'(half_n), int'(mhalf));
    chk(perr == merr, {ctx, " R10 err"}, int'(perr), int'(merr));
  endtask

  task automatic m_reset();
    mc = 0; mw = 0; mr = 0; mtot = 0; mhalf = 1; merr = 0; mlast = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_n = 1; rd_n = 1; rt_n = 1;
    repeat (2) @(negedge clk);
    rst_n = 1; m_reset();
    @(negedge clk);
  endtask

  task automatic do_wr(input logic [W-1:0] d, input string tag);
    @(negedge clk); wdata = d; wr_n = 0;
    @(negedge clk);
    if (mc < D) begin
      if (mc >= H) mhalf = 0;
      mm[mw] = d; mw = (mw + 1) % D; mc++;
      if (mtot < D) mtot++;
    end
    chk_flags(tag);
    wr_n = 1;
    @(negedge clk);
  endtask

  task automatic do_rd(input string tag);
    @(negedge clk); rd_n = 0;
    @(negedge clk);
    if (mc > 0) begin
      mlast = mm[mr]; mr = (mr + 1) % D; mc--;
    end
    chk(rdata == mlast, {tag, " R3 data"}, int'(rdata), int'(mlast));
    chk_flags(tag);
    rd_n = 1;
    @(negedge clk);
    if (mc <= H) mhalf = 1;
    chk_flags(tag);
  endtask

  task automatic do_both(input logic [W-1:0] d);
    bit wok, rok;
    @(negedge clk); wdata = d; wr_n = 0; rd_n = 0;
    @(negedge clk);
    wok = (mc < D); rok = (mc > 0);
    if (rok) begin mlast = mm[mr]; mr = (mr + 1) % D; end
    if (wok) begin
      if (mc >= H) mhalf = 0;
      mm[mw] = d; mw = (mw + 1) % D;
      if (mtot < D) mtot++;
    end
    mc = mc + int'(wok) - int'(rok);
    chk(rdata == mlast, "R11 both data", int'(rdata), int'(mlast));
    chk_flags("R11 both");
    wr_n = 1; rd_n = 1;
    @(negedge clk);
    if (mc <= H) mhalf = 1;
    chk_flags("R11 both rise");
  endtask

  task automatic m_rt();
    mr = 0; mc = mtot; mhalf = !(mc > H);
  endtask

  task automatic do_rt();
    @(negedge clk); rt_n = 0;
    @(negedge clk); m_rt(); chk_flags("R9 rewind");
    rt_n = 1;
    @(negedge clk); chk_flags("R9 after rewind");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset with write strobe held low across release
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk_flags("R1 strobe held low");
    chk(rdata == '0, "R1 rdata", int'(rdata), 0);
    wr_n = 1;
    @(negedge clk);
    chk_flags("R1 after release");

    // Fill to full (R2, R4, R8), overfill (R6)
    for (int i = 0; i < D; i++) do_wr(W'(i * 37 + 5), "R2 fill");
    chk(full_n == 0, "R4 full after DEPTH writes", int'(full_n), 0);
    do_wr(W'(500), "R6 write while full");
    do_wr(W'(501), "R6 write while full");
    // Drain (R2 order, R3, R5), overdrain (R7)
    for (int i = 0; i < D; i++) do_rd("R2 drain");
    chk(empty_n == 0, "R5 empty after drain", int'(empty_n), 0);
    do_rd("R7 read while empty");
    do_rd("R7 read while empty");

    // Wrap-around and half hysteresis (R3, R8)
    for (int i = 0; i < 5; i++) do_wr(W'(100 + i), "R8 wrap fill");
    for (int i = 0; i < 3; i++) do_rd("R8 wrap read");
    for (int i = 0; i < 6; i++) do_wr(W'(200 + i), "R3 wrap fill");
    for (int i = 0; i < D; i++) do_rd("R3 wrap drain");

    // Simultaneous strobes (R11): empty, mid, full
    do_reset();
    do_both(W'(300));
    for (int i = 0; i < 2; i++) do_wr(W'(310 + i), "R11 prep");
    do_both(W'(320));
    for (int i = 0; i < D; i++) do_wr(W'(330 + i), "R11 prep full");
    do_both(W'(340));
    for (int i = 0; i < D; i++) do_rd("R11 drain");

    // Rewind sweep (R9)
    for (int k = 1; k <= D; k++) begin
      for (int j = 0; j <= k; j++) begin
        do_reset();
        for (int i = 0; i < k; i++) do_wr(W'((k * 16 + i) & 511), "R9 load");
        for (int i = 0; i < j; i++) do_rd("R9 pre-read");
        do_rt();
        for (int i = 0; i < k; i++) do_rd("R9 replay");
        chk(empty_n == 0, "R9 empty after replay", int'(empty_n), 0);
      end
    end

    // Strobes during rewind (R10)
    do_reset();
    for (int i = 0; i < 3; i++) do_wr(W'(400 + i), "R10 load");
    do_rd("R10 pre-read");
    @(negedge clk); rt_n = 0;
    @(negedge clk); wdata = W'(77); wr_n = 0;
    @(negedge clk); wr_n = 1; rd_n = 0;
    @(negedge clk); rd_n = 1;
    @(negedge clk);
    m_rt(); merr = 1;
    chk_flags("R10 during rewind");
    rt_n = 1;
    @(negedge clk);
    chk(perr == 1, "R10 sticky", int'(perr), 1);
    for (int i = 0; i < 3; i++) do_rd("R10 replay");
    chk(empty_n == 0, "R10 no stray write", int'(empty_n), 0);
    do_reset();
    chk_flags("R1 error cleared");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule